// File: doc/BRIEF.md
# Indexed VGA Register Port Decoder

This block sits behind a byte-wide host I/O bus and turns an 8-bit port offset into accesses on a VGA-style register file. A single external register, the miscellaneous output byte, is written through one offset and read back through a different one. Three indexed groups sit beside it: sequencer, graphics and CRT controller. Each group has two ports. A write to the index port selects a sub-register, and the index can be read back. Reads and writes on the data port then reach the selected sub-register.

Each group keeps only as many index bits as its register count needs. The upper bits of a written index are dropped, and they read back as zero. An index with no register behind it reads as 00h and ignores writes. The CRT controller has a protect bit. When it is set, writes to the low timing registers are blocked, and one register accepts only a single bit. The host bus is simple. A write takes effect at the clock edge. Read data is combinational from the offset presented while the read strobe is high.

Top module: `vgaio_port_decoder`

## Requirements
- R1: After a synchronous active-low reset, every register reads 00h: the miscellaneous output byte, all three index registers and every data sub-register.
- R2: A write at offset C2h loads the miscellaneous output byte, and a read at offset CCh returns it. A read at C2h returns 00h, and a write at CCh leaves the byte unchanged.
- R3: A write to an index port (sequencer C4h, graphics CEh, CRT controller D4h) keeps the low 3, 4 or 5 bits respectively. A read of the same port returns those bits with the upper bits zero.
- R4: The data ports (C5h, CFh, D5h) read and write the sub-register chosen by their own group's index. The valid index ranges are 00h–04h for the sequencer, 00h–08h for graphics and 00h–18h for the CRT controller. The three groups are independent of each other.
- R5: When a data port is accessed with an index above its group's range, the read returns 00h and the write changes no register.
- R6: While bit 7 of CRT controller register 11h is 1, data writes to CRT indices 00h–06h are ignored. A data write to CRT index 07h then changes only bit 4. All other CRT indices, including 11h itself, stay writable.
- R7: A write to any offset not listed in R2–R4 changes no register, and a read of such an offset returns 00h.
- R8: While the read strobe is low, the read data bus is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| port_ofs | input | 8 | Low byte of the I/O port address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the same cycle as rd_en |

## Verification
The data ports are tried with a sweep that writes every CRT index with a value derived from the index itself, so an aliased or misdecoded index shows up as a wrong byte on readback. Each group's data port is also written at the same index with a different byte, which shows whether the groups are independent. Index ports are written with FFh, so the readback shows whether each group keeps exactly the intended number of bits. Protected writes are made with the protect bit both set and clear, which separates full blocking, the single-bit pass-through at index 07h, and normal writes.

// File: rtl/vgaio_pkg.sv
// Package: port offsets, group sizes and the shared decode types
// for the indexed VGA register port decoder.
package vgaio_pkg;

    localparam int DW = 8;

    localparam logic [7:0] OFS_MISC_WR = 8'hC2;
    localparam logic [7:0] OFS_MISC_RD = 8'hCC;
    localparam logic [7:0] OFS_SEQ_IDX = 8'hC4;
    localparam logic [7:0] OFS_SEQ_DAT = 8'hC5;
    localparam logic [7:0] OFS_GFX_IDX = 8'hCE;
    localparam logic [7:0] OFS_GFX_DAT = 8'hCF;
    localparam logic [7:0] OFS_CRT_IDX = 8'hD4;
    localparam logic [7:0] OFS_CRT_DAT = 8'hD5;

    localparam int SEQ_NREG = 5;
    localparam int GFX_NREG = 9;
    localparam int CRT_NREG = 25;

    // CRT protect: register/bit holding the enable, first index left
    // open, and the bits still writable at that partially open index.
    localparam int             CRT_LOCK_REG  = 17;
    localparam int             CRT_LOCK_BIT  = 7;
    localparam int             CRT_LOCK_LAST = 7;
    localparam logic [DW-1:0]  CRT_PART_MASK = 8'h10;

    // One write strobe per writable port.
    typedef struct packed {
        logic misc;
        logic seq_idx;
        logic seq_dat;
        logic gfx_idx;
        logic gfx_dat;
        logic crt_idx;
        logic crt_dat;
    } wstb_t;

    // Source selected for the read data bus.
    typedef enum logic [3:0] {
        RS_NONE,
        RS_MISC,
        RS_SEQ_IDX,
        RS_SEQ_DAT,
        RS_GFX_IDX,
        RS_GFX_DAT,
        RS_CRT_IDX,
        RS_CRT_DAT
    } rsel_t;

endpackage

// File: rtl/vgaio_addr_decode.sv
// Address decoder: turns the port offset and the strobes into one
// write strobe per port and a read source select.
// Assumes at most one access (read or write) per offset per cycle.
module vgaio_addr_decode
    import vgaio_pkg::*;
(
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] port_ofs,
    output wstb_t      wstb,
    output rsel_t      rsel
);

    // Write decode: the read-only offset CCh has no write strobe.
    always_comb begin
        wstb = '0;
        if (wr_en) begin
            unique case (port_ofs)
                OFS_MISC_WR: wstb.misc    = 1'b1;
                OFS_SEQ_IDX: wstb.seq_idx = 1'b1;
                OFS_SEQ_DAT: wstb.seq_dat = 1'b1;
                OFS_GFX_IDX: wstb.gfx_idx = 1'b1;
                OFS_GFX_DAT: wstb.gfx_dat = 1'b1;
                OFS_CRT_IDX: wstb.crt_idx = 1'b1;
                OFS_CRT_DAT: wstb.crt_dat = 1'b1;
                default:     wstb         = '0;
            endcase
        end
    end

    // Read decode: the miscellaneous byte is read only at its own offset.
    always_comb begin
        rsel = RS_NONE;
        if (rd_en) begin
            unique case (port_ofs)
                OFS_MISC_RD: rsel = RS_MISC;
                OFS_SEQ_IDX: rsel = RS_SEQ_IDX;
                OFS_SEQ_DAT: rsel = RS_SEQ_DAT;
                OFS_GFX_IDX: rsel = RS_GFX_IDX;
                OFS_GFX_DAT: rsel = RS_GFX_DAT;
                OFS_CRT_IDX: rsel = RS_CRT_IDX;
                OFS_CRT_DAT: rsel = RS_CRT_DAT;
                default:     rsel = RS_NONE;
            endcase
        end
    end

endmodule

// File: rtl/vgaio_ext_reg.sv
// External register: one byte loaded by its write strobe.
// Assumes the strobe is already decoded from its write-only offset.
module vgaio_ext_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);

    // Hold the byte; clear on reset, load on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (wr) q <= wdata;
    end

    // R1: reset clears the byte.
    a_r1_ext_reset: assert property (@(posedge clk) !rst_n |=> q == '0);

    // R2: a load shows up on the next cycle.
    a_r2_ext_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> q == $past(wdata));

endmodule

// File: rtl/vgaio_idx_group.sv
// Indexed register group: an index register of IDX_W bits plus NREG
// data sub-registers reached through the data port. Indices at or above
// NREG read 0 and absorb writes. With LOCK_EN set, a bit inside the
// group blocks data writes below LOCK_LAST and limits writes at
// LOCK_LAST to PART_MASK.
// Assumes index and data strobes never occur in the same cycle.
module vgaio_idx_group #(
    parameter int            DW        = 8,
    parameter int            NREG      = 5,
    parameter int            IDX_W     = (NREG > 1) ? $clog2(NREG) : 1,
    parameter bit            LOCK_EN   = 1'b0,
    parameter int            LOCK_REG  = 0,
    parameter int            LOCK_BIT  = 0,
    parameter int            LOCK_LAST = 0,
    parameter logic [DW-1:0] PART_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic             dat_wr,
    input  logic [DW-1:0]    wdata,
    output logic [IDX_W-1:0] idx_q,
    output logic [DW-1:0]    dat_rd
);

    logic [NREG-1:0][DW-1:0] reg_q;
    logic [DW-1:0]           wmask;
    logic                    in_range;

    assign in_range = (int'(idx_q) < NREG);

    // Index register: keep only the low IDX_W bits of the written byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_wr) idx_q <= wdata[IDX_W-1:0];
    end

    // Per-index write mask, tightened by the protect bit when present.
    generate
        if (LOCK_EN) begin : g_lock
            logic lock_on;
            assign lock_on = reg_q[LOCK_REG][LOCK_BIT];

            // Pick the write mask from the protect bit and the index.
            always_comb begin
                wmask = '1;
                if (lock_on) begin
                    if (int'(idx_q) < LOCK_LAST)       wmask = '0;
                    else if (int'(idx_q) == LOCK_LAST) wmask = PART_MASK;
                end
            end

            // R6: protected indices keep every bit.
            a_r6_lock_block: assert property (@(posedge clk) disable iff (!rst_n)
                (dat_wr && lock_on && int'(idx_q) < LOCK_LAST) |=> $stable(reg_q));

            // R6: the partially open index changes only its open bits.
            a_r6_lock_partial: assert property (@(posedge clk) disable iff (!rst_n)
                (dat_wr && lock_on && int'(idx_q) == LOCK_LAST)
                |=> ((dat_rd ^ $past(dat_rd)) & ~PART_MASK) == '0);
        end else begin : g_open
            assign wmask = '1;
        end
    endgenerate

    // Data sub-registers: masked merge of the write into the selected one.
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            // Update sub-register g when it is the selected index.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    reg_q[g] <= '0;
                else if (dat_wr && idx_q == IDX_W'(g))
                    reg_q[g] <= (reg_q[g] & ~wmask) | (wdata & wmask);
            end
        end
    endgenerate

    // Data read mux: the selected sub-register, or 0 outside the range.
    always_comb begin
        dat_rd = '0;
        for (int i = 0; i < NREG; i++)
            if (idx_q == IDX_W'(i)) dat_rd = reg_q[i];
    end

    // R1: reset clears the index and every sub-register.
    a_r1_grp_reset: assert property (@(posedge clk)
        !rst_n |=> (idx_q == '0 && reg_q == '0));

    // R3: the index keeps the low bits of the written byte.
    a_r3_idx_capture: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> idx_q == $past(wdata[IDX_W-1:0]));

    // R4: a data write is visible through the read mux on its open bits.
    a_r4_data_write: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && in_range) |=> (dat_rd & $past(wmask)) == ($past(wdata) & $past(wmask)));

    // R5: writes outside the range leave every sub-register alone.
    a_r5_oor_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !in_range) |=> $stable(reg_q));

    // R5: reads outside the range return 0.
    a_r5_oor_read: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> dat_rd == '0);

endmodule

// File: rtl/vgaio_port_decoder.sv
// Top: byte-wide I/O port decoder for a VGA-style register set.
// Holds the miscellaneous output byte and the sequencer, graphics and
// CRT controller indexed groups; the CRT group carries write protection.
// Assumes one bus access per cycle; read data is combinational.
module vgaio_port_decoder
    import vgaio_pkg::*;
#(
    parameter int SEQ_REGS = SEQ_NREG,
    parameter int GFX_REGS = GFX_NREG,
    parameter int CRT_REGS = CRT_NREG
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] port_ofs,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);

    localparam int SEQ_IW = (SEQ_REGS > 1) ? $clog2(SEQ_REGS) : 1;
    localparam int GFX_IW = (GFX_REGS > 1) ? $clog2(GFX_REGS) : 1;
    localparam int CRT_IW = (CRT_REGS > 1) ? $clog2(CRT_REGS) : 1;

    wstb_t              wstb;
    rsel_t              rsel;
    logic [DW-1:0]      misc_q;
    logic [SEQ_IW-1:0]  seq_idx;
    logic [GFX_IW-1:0]  gfx_idx;
    logic [CRT_IW-1:0]  crt_idx;
    logic [DW-1:0]      seq_dat, gfx_dat, crt_dat;

    vgaio_addr_decode u_dec (
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .port_ofs (port_ofs),
        .wstb     (wstb),
        .rsel     (rsel)
    );

    vgaio_ext_reg #(.DW(DW)) u_misc (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wstb.misc),
        .wdata (wdata),
        .q     (misc_q)
    );

    vgaio_idx_group #(.DW(DW), .NREG(SEQ_REGS), .IDX_W(SEQ_IW)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (wstb.seq_idx),
        .dat_wr (wstb.seq_dat),
        .wdata  (wdata),
        .idx_q  (seq_idx),
        .dat_rd (seq_dat)
    );

    vgaio_idx_group #(.DW(DW), .NREG(GFX_REGS), .IDX_W(GFX_IW)) u_gfx (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (wstb.gfx_idx),
        .dat_wr (wstb.gfx_dat),
        .wdata  (wdata),
        .idx_q  (gfx_idx),
        .dat_rd (gfx_dat)
    );

    vgaio_idx_group #(
        .DW        (DW),
        .NREG      (CRT_REGS),
        .IDX_W     (CRT_IW),
        .LOCK_EN   (1'b1),
        .LOCK_REG  (CRT_LOCK_REG),
        .LOCK_BIT  (CRT_LOCK_BIT),
        .LOCK_LAST (CRT_LOCK_LAST),
        .PART_MASK (CRT_PART_MASK)
    ) u_crt (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (wstb.crt_idx),
        .dat_wr (wstb.crt_dat),
        .wdata  (wdata),
        .idx_q  (crt_idx),
        .dat_rd (crt_dat)
    );

    // Read mux: route the selected source, indices zero-extended.
    always_comb begin
        unique case (rsel)
            RS_MISC:    rdata = misc_q;
            RS_SEQ_IDX: rdata = DW'(seq_idx);
            RS_SEQ_DAT: rdata = seq_dat;
            RS_GFX_IDX: rdata = DW'(gfx_idx);
            RS_GFX_DAT: rdata = gfx_dat;
            RS_CRT_IDX: rdata = DW'(crt_idx);
            RS_CRT_DAT: rdata = crt_dat;
            default:    rdata = '0;
        endcase
    end

    // R8: an idle read strobe leaves the bus at 0.
    a_r8_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == '0);

    // R2: a write at the read-back offset leaves the byte unchanged.
    a_r2_misc_rdport_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port_ofs == OFS_MISC_RD) |=> $stable(misc_q));

    // R7: writes to an unlisted offset move no index.
    a_r7_unmapped_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wstb == '0) |=> ($stable(seq_idx) && $stable(gfx_idx) && $stable(crt_idx)));

endmodule

// File: tb/vgaio_port_decoder_tb.sv
// Directed bench for the indexed VGA register port decoder.
module vgaio_port_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] port_ofs = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    vgaio_port_decoder dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .port_ofs (port_ofs),
        .wdata    (wdata),
        .rdata    (rdata)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] ofs, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; port_ofs = ofs; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] ofs, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; port_ofs = ofs;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] ofs, input logic [7:0] exp);
        logic [7:0] v;
        bus_rd(ofs, v);
        check(tag, v, exp);
    endtask

    // R1: every register is 00h after reset.
    task automatic t_reset();
        rd_chk("R1 misc", 8'hCC, 8'h00);
        rd_chk("R1 seq idx", 8'hC4, 8'h00);
        rd_chk("R1 seq dat", 8'hC5, 8'h00);
        rd_chk("R1 gfx idx", 8'hCE, 8'h00);
        rd_chk("R1 gfx dat", 8'hCF, 8'h00);
        rd_chk("R1 crt idx", 8'hD4, 8'h00);
        rd_chk("R1 crt dat", 8'hD5, 8'h00);
    endtask

    // R8: idle read strobe gives a zero bus.
    task automatic t_idle();
        @(negedge clk);
        port_ofs = 8'hCC;
        #1 check("R8 idle bus", rdata, 8'h00);
    endtask

    // R2: split write/read offsets for the miscellaneous byte.
    task automatic t_misc();
        bus_wr(8'hC2, 8'hA5);
        rd_chk("R2 misc readback", 8'hCC, 8'hA5);
        rd_chk("R2 read at write offset", 8'hC2, 8'h00);
        bus_wr(8'hCC, 8'hFF);
        rd_chk("R2 write at read offset ignored", 8'hCC, 8'hA5);
    endtask

    // R3: index width per group.
    task automatic t_index();
        bus_wr(8'hC4, 8'hFF); rd_chk("R3 seq idx 3 bits", 8'hC4, 8'h07);
        bus_wr(8'hCE, 8'hFF); rd_chk("R3 gfx idx 4 bits", 8'hCE, 8'h0F);
        bus_wr(8'hD4, 8'hFF); rd_chk("R3 crt idx 5 bits", 8'hD4, 8'h1F);
    endtask

    // R4: data ports per group, independent, plus a full CRT sweep.
    task automatic t_data();
        bus_wr(8'hC4, 8'h02); bus_wr(8'hC5, 8'h3C);
        bus_wr(8'hCE, 8'h02); bus_wr(8'hCF, 8'h5A);
        bus_wr(8'hD4, 8'h02); bus_wr(8'hD5, 8'h77);
        rd_chk("R4 seq data", 8'hC5, 8'h3C);
        rd_chk("R4 gfx data", 8'hCF, 8'h5A);
        rd_chk("R4 crt data", 8'hD5, 8'h77);
        for (int i = 0; i < 25; i++) begin
            bus_wr(8'hD4, 8'(i));
            bus_wr(8'hD5, 8'(i) ^ 8'h56);
        end
        for (int i = 0; i < 25; i++) begin
            bus_wr(8'hD4, 8'(i));
            rd_chk($sformatf("R4 crt sweep idx %0d", i), 8'hD5, 8'(i) ^ 8'h56);
        end
        bus_wr(8'hC4, 8'h04); bus_wr(8'hC5, 8'hE1);
        bus_wr(8'hC4, 8'h02);
        rd_chk("R4 seq idx2 kept", 8'hC5, 8'h3C);
    endtask

    // R5: indices past the range read 0 and absorb writes.
    task automatic t_oor();
        bus_wr(8'hC4, 8'h05); bus_wr(8'hC5, 8'h11);
        rd_chk("R5 seq oor read", 8'hC5, 8'h00);
        bus_wr(8'hC4, 8'h00);
        rd_chk("R5 seq idx0 untouched", 8'hC5, 8'h00);
        bus_wr(8'hCE, 8'h09); bus_wr(8'hCF, 8'h22);
        rd_chk("R5 gfx oor read", 8'hCF, 8'h00);
        bus_wr(8'hCE, 8'h01);
        rd_chk("R5 gfx idx1 untouched", 8'hCF, 8'h00);
        bus_wr(8'hD4, 8'h19); bus_wr(8'hD5, 8'h33);
        rd_chk("R5 crt oor read", 8'hD5, 8'h00);
        bus_wr(8'hD4, 8'h18);
        rd_chk("R5 crt idx18 untouched", 8'hD5, 8'h18 ^ 8'h56);
    endtask

    // R6: CRT protect bit.
    task automatic t_lock();
        bus_wr(8'hD4, 8'h11); bus_wr(8'hD5, 8'h80);
        bus_wr(8'hD4, 8'h03); bus_wr(8'hD5, 8'hFF);
        rd_chk("R6 idx3 blocked", 8'hD5, 8'h55);
        bus_wr(8'hD4, 8'h00); bus_wr(8'hD5, 8'hFF);
        rd_chk("R6 idx0 blocked", 8'hD5, 8'h56);
        bus_wr(8'hD4, 8'h07); bus_wr(8'hD5, 8'h00);
        rd_chk("R6 idx7 only bit4", 8'hD5, 8'h41);
        bus_wr(8'hD5, 8'hFF);
        rd_chk("R6 idx7 bit4 set", 8'hD5, 8'h51);
        bus_wr(8'hD4, 8'h08); bus_wr(8'hD5, 8'h42);
        rd_chk("R6 idx8 open", 8'hD5, 8'h42);
        bus_wr(8'hD4, 8'h11); bus_wr(8'hD5, 8'h00);
        rd_chk("R6 lock reg writable", 8'hD5, 8'h00);
        bus_wr(8'hD4, 8'h03); bus_wr(8'hD5, 8'h33);
        rd_chk("R6 idx3 open after clear", 8'hD5, 8'h33);
    endtask

    // R7: unlisted offsets.
    task automatic t_unmapped();
        bus_wr(8'hC3, 8'hFF);
        bus_wr(8'hD6, 8'hFF);
        bus_wr(8'h00, 8'hFF);
        rd_chk("R7 unmapped read", 8'hC3, 8'h00);
        rd_chk("R7 misc kept", 8'hCC, 8'hA5);
        rd_chk("R7 crt idx kept", 8'hD4, 8'h03);
        rd_chk("R7 crt data kept", 8'hD5, 8'h33);
        rd_chk("R7 seq idx kept", 8'hC4, 8'h00);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_idle();
        t_misc();
        t_index();
        t_data();
        t_oor();
        t_lock();
        t_unmapped();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule